// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches sixteen external event lines and turns their edges into latched pending flags and three grouped interrupt requests. Each line takes its input from one of several 16-bit GPIO ports. Line N always samples bit N of the port it selects, so for any one line number only one port can be the source at a time. The selected input passes through a two-flop synchronizer. An edge detector then compares the synchronized value with its value one cycle earlier.

Software sets the controller up through a small word-wide register interface. Through it, software chooses the source port of each line, enables rising and falling edges separately, masks lines, and acknowledges events. A pending flag clears only when software writes a one to its position, so one line can be acknowledged without disturbing others that are still pending. The sixteen lines feed three interrupt requests of unequal size. An unacknowledged line holds its request high until it is cleared.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all three interrupt outputs are low.
- R2: Address w (0 to 3) holds the 4-bit source codes for lines 4w to 4w+3, with the lowest-numbered of those lines in bits 3:0. Code k selects bit N of port k, where port k occupies `port_in[16k+15:16k]`. Codes 6 to 15 select a constant 0, so the line never sees an edge.
- R3: Suppose a 0-to-1 transition appears on a line's selected input between clock edges, and the line's bit in the rise-enable register (address 4) is 1. Then that line's pending bit reads 1 after exactly three rising clock edges, and reads 0 after two.
- R4: A 1-to-0 transition sets the pending bit when the line's bit in the fall-enable register (address 5) is 1. With both enables set, either direction sets it.
- R5: A transition in a direction whose enable bit is 0 leaves the pending bit unchanged.
- R6: A pending bit (address 7) stays set until a write to address 7 with a 1 in that position clears it. Zero bits in that write have no effect on other pending bits.
- R7: If an enabled edge and a write-1 clear reach the same pending bit in the same cycle, the bit stays set.
- R8: A pending line drives its group request only while its bit in the mask register (address 6) is 1. A masked line still latches its pending bit.
- R9: `irq_grp0_1` is high while line 0 or 1 is pending and unmasked. `irq_grp2_3` does the same for lines 2 and 3, and `irq_grp4_15` for lines 4 to 15.
- R10: `rd_data` returns the register at `addr` in the same cycle. Addresses 8 to 15 read as 0 and ignore writes.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_in | input | 96 | Six 16-bit GPIO ports packed, port k at bits 16k+15:16k |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| irq_grp0_1 | output | 1 | Request for lines 0 and 1 |
| irq_grp2_3 | output | 1 | Request for lines 2 and 3 |
| irq_grp4_15 | output | 1 | Request for lines 4 to 15 |

## Verification
The assertions check the pending-flag rules on every cycle. An enabled edge always lands in the pending register, even against a clear. No pending bit appears without an edge. A set bit survives every cycle in which no one was written to its position, and an uncontested clear removes it. They also check that no request rises while all lines are masked or nothing is pending. The bench scenarios are needed for everything that depends on configuration. That covers the nibble that routes each line to its port, the inert codes above the port count, the three-edge latency, the direction enables, the group boundaries and the register readback.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 4;
endpackage

// File: rtl/eic_src_mux.sv
module eic_src_mux #(
    parameter int LINES  = 16,
    parameter int PORTS  = 6,
    parameter int PORT_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic [PORTS*PORT_W-1:0] port_in,
    input  logic [LINES*SEL_W-1:0]  sel,
    output logic [LINES-1:0]        line_raw
);
    // One selector per line; unmatched codes fall through to 0.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [SEL_W-1:0] code;
        logic             pick;
        assign code = sel[g*SEL_W +: SEL_W];
        always_comb begin
            pick = 1'b0;
            for (int p = 0; p < PORTS; p++) begin
                if (code == SEL_W'(p)) pick = port_in[p*PORT_W + g];
            end
        end
        assign line_raw[g] = pick;
    end
endmodule

// File: rtl/eic_edge_det.sv
module eic_edge_det #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    input  logic [LINES-1:0] rise_en,
    input  logic [LINES-1:0] fall_en,
    output logic [LINES-1:0] trig
);
    typedef struct packed {
        logic [LINES-1:0] s1;
        logic [LINES-1:0] s2;
        logic [LINES-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = raw;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        trig = (st_q.s2 & ~st_q.prev & rise_en)
             | (~st_q.s2 & st_q.prev & fall_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/eic_regs.sv
module eic_regs #(
    parameter int LINES  = 16,
    parameter int SEL_W  = 4,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [LINES-1:0]       wr_data,
    input  logic [LINES-1:0]       trig,
    input  logic [LINES-1:0]       clr_vec,
    output logic [LINES*SEL_W-1:0] sel,
    output logic [LINES-1:0]       rise_en,
    output logic [LINES-1:0]       fall_en,
    output logic [LINES-1:0]       mask,
    output logic [LINES-1:0]       pend,
    output logic [LINES-1:0]       rd_data
);
    localparam int NSEL   = (LINES * SEL_W) / LINES;
    localparam int A_RISE = NSEL;
    localparam int A_FALL = NSEL + 1;
    localparam int A_MASK = NSEL + 2;
    localparam int A_PEND = NSEL + 3;

    typedef struct packed {
        logic [LINES*SEL_W-1:0] sel;
        logic [LINES-1:0]       rise;
        logic [LINES-1:0]       fall;
        logic [LINES-1:0]       mask;
        logic [LINES-1:0]       pend;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int w = 0; w < NSEL; w++) begin
                if (addr == ADDR_W'(w)) st_d.sel[w*LINES +: LINES] = wr_data;
            end
            if (addr == ADDR_W'(A_RISE)) st_d.rise = wr_data;
            if (addr == ADDR_W'(A_FALL)) st_d.fall = wr_data;
            if (addr == ADDR_W'(A_MASK)) st_d.mask = wr_data;
        end
        // A new edge takes precedence over an acknowledge in the same cycle.
        st_d.pend = (st_q.pend & ~clr_vec) | trig;
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NSEL; w++) begin
            if (addr == ADDR_W'(w)) rd_data = st_q.sel[w*LINES +: LINES];
        end
        if (addr == ADDR_W'(A_RISE)) rd_data = st_q.rise;
        if (addr == ADDR_W'(A_FALL)) rd_data = st_q.fall;
        if (addr == ADDR_W'(A_MASK)) rd_data = st_q.mask;
        if (addr == ADDR_W'(A_PEND)) rd_data = st_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel     = st_q.sel;
    assign rise_en = st_q.rise;
    assign fall_en = st_q.fall;
    assign mask    = st_q.mask;
    assign pend    = st_q.pend;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int PORTS  = 6,
    parameter int PORT_W = 16,
    parameter int G1_LO  = 2,
    parameter int G2_LO  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PORTS*PORT_W-1:0] port_in,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LINES-1:0]        wr_data,
    output logic [LINES-1:0]        rd_data,
    output logic                    irq_grp0_1,
    output logic                    irq_grp2_3,
    output logic                    irq_grp4_15
);
    localparam int NSEL   = (LINES * SEL_W) / LINES;
    localparam int A_PEND = NSEL + 3;

    logic [LINES*SEL_W-1:0] sel_vec;
    logic [LINES-1:0] raw_vec, rise_vec, fall_vec, mask_vec, pend_vec;
    logic [LINES-1:0] trig_vec, clr_vec, active;

    assign clr_vec = (wr_en && addr == ADDR_W'(A_PEND)) ? wr_data : '0;

    eic_src_mux #(.LINES(LINES), .PORTS(PORTS), .PORT_W(PORT_W), .SEL_W(SEL_W)) u_mux (
        .port_in (port_in),
        .sel     (sel_vec),
        .line_raw(raw_vec)
    );

    eic_edge_det #(.LINES(LINES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_vec),
        .rise_en(rise_vec),
        .fall_en(fall_vec),
        .trig   (trig_vec)
    );

    eic_regs #(.LINES(LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .trig   (trig_vec),
        .clr_vec(clr_vec),
        .sel    (sel_vec),
        .rise_en(rise_vec),
        .fall_en(fall_vec),
        .mask   (mask_vec),
        .pend   (pend_vec),
        .rd_data(rd_data)
    );

    assign active      = pend_vec & mask_vec;
    assign irq_grp0_1  = |active[G1_LO-1:0];
    assign irq_grp2_3  = |active[G2_LO-1:G1_LO];
    assign irq_grp4_15 = |active[LINES-1:G2_LO];
endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] pend,
    input logic [LINES-1:0] mask,
    input logic [LINES-1:0] trig,
    input logic [LINES-1:0] clr,
    input logic [2:0]       irq
);
    p_edge_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig) & ~pend) == '0));

    p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(trig) & $past(clr) & ~pend) == '0));

    p_no_spurious_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(trig)) == '0));

    p_pend_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(clr) & ~pend) == '0));

    p_clear_works_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr) & ~$past(trig)) == '0));

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (irq == 3'b000));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (irq == 3'b000));
endmodule

bind ext_irq_ctrl eic_checker #(.LINES(LINES)) u_eic_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .pend (pend_vec),
    .mask (mask_vec),
    .trig (trig_vec),
    .clr  (clr_vec),
    .irq  ({irq_grp4_15, irq_grp2_3, irq_grp0_1})
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT  = 6;
    localparam int PW     = 16;
    localparam logic [3:0] A_RISE = 4'd4;
    localparam logic [3:0] A_FALL = 4'd5;
    localparam logic [3:0] A_MASK = 4'd6;
    localparam logic [3:0] A_PEND = 4'd7;

    typedef struct packed {
        logic [3:0] line;
        logic [3:0] code;
        logic [3:0] drv;   // port driven; 4'hF drives every port
        logic       rise;
        logic       fall;
        logic       dir;   // 1: 0->1 transition, 0: 1->0
        logic       exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  4'd1, 4'd1, 1'b1, 1'b0, 1'b1, 1'b1},
        '{4'd3,  4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        '{4'd7,  4'd5, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'd15, 4'd3, 4'd3, 1'b1, 1'b1, 1'b1, 1'b1},
        '{4'd9,  4'd7, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'd4,  4'd4, 4'd4, 1'b0, 1'b0, 1'b1, 1'b0},
        '{4'd12, 4'd2, 4'd2, 1'b1, 1'b1, 1'b0, 1'b1},
        '{4'd6,  4'd1, 4'd0, 1'b1, 1'b1, 1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NPORT*PW-1:0] port_in = '0;
    logic wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic irq_grp0_1, irq_grp2_3, irq_grp4_15;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .port_in(port_in),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .irq_grp0_1(irq_grp0_1), .irq_grp2_3(irq_grp2_3), .irq_grp4_15(irq_grp4_15)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic drive(input vec_t v, input logic level);
        if (v.drv == 4'hF) begin
            for (int p = 0; p < NPORT; p++) port_in[p*PW + int'(v.line)] = level;
        end else begin
            port_in[int'(v.drv)*PW + int'(v.line)] = level;
        end
    endtask

    function automatic logic [2:0] irqs();
        return {irq_grp4_15, irq_grp2_3, irq_grp0_1};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            chk("R1 reset register", d, 0);
        end
        chk("R1 reset irq", irqs(), 0);

        // R10: readback and unused addresses
        wr(4'd2, 16'h1234);
        rd(4'd2, d); chk("R10 sel word readback", d, 16'h1234);
        wr(A_RISE, 16'hA5A5);
        rd(A_RISE, d); chk("R10 rise readback", d, 16'hA5A5);
        wr(4'd9, 16'hFFFF);
        rd(4'd9, d); chk("R10 unused addr", d, 0);
        wr(4'd2, 16'h0000);
        wr(A_RISE, 16'h0000);

        // R2 R3 R4 R5 R9: vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            logic [15:0] word;
            int grp;
            v = VECS[i];
            wr(A_RISE, 0);
            wr(A_FALL, 0);
            port_in = '0;
            waitc(4);
            wr(A_PEND, 16'hFFFF);
            word = 16'(v.code) << (4 * (int'(v.line) % 4));
            for (int w = 0; w < 4; w++)
                wr(4'(w), (w == int'(v.line) / 4) ? word : 16'h0000);
            wr(A_MASK, 16'hFFFF);
            drive(v, ~v.dir);
            waitc(4);
            wr(A_RISE, 16'(v.rise) << v.line);
            wr(A_FALL, 16'(v.fall) << v.line);
            drive(v, v.dir);
            waitc(3);
            rd(A_PEND, d);
            chk($sformatf("R2 R3 R4 R5 vector %0d pending", i), d,
                v.exp ? (32'h1 << v.line) : 0);
            grp = (v.line < 2) ? 0 : (v.line < 4) ? 1 : 2;
            chk($sformatf("R9 vector %0d group", i), irqs(),
                v.exp ? (32'h1 << grp) : 0);
        end

        wr(A_RISE, 0);
        wr(A_FALL, 0);
        port_in = '0;
        for (int w = 0; w < 4; w++) wr(4'(w), 0);
        waitc(4);
        wr(A_PEND, 16'hFFFF);

        // R3: latency of exactly three edges
        wr(A_RISE, 16'h0022);
        @(negedge clk);
        port_in[5] = 1'b1;
        waitc(2);
        rd(A_PEND, d); chk("R3 not yet after two edges", d, 0);
        waitc(1);
        rd(A_PEND, d); chk("R3 set after three edges", d, 16'h0020);
        chk("R9 line5 in group 4-15", irqs(), 3'b100);

        // R6: write-1 clear, write-0 no effect
        port_in[1] = 1'b1;
        waitc(3);
        rd(A_PEND, d); chk("R6 two pending", d, 16'h0022);
        wr(A_PEND, 16'h0000);
        rd(A_PEND, d); chk("R6 zero write ignored", d, 16'h0022);
        wr(A_PEND, 16'h0020);
        rd(A_PEND, d); chk("R6 selective clear", d, 16'h0002);
        chk("R9 line1 holds group 0-1", irqs(), 3'b001);
        wr(A_PEND, 16'h0002);
        rd(A_PEND, d); chk("R6 all cleared", d, 0);

        // R8: mask gates request but not latching
        wr(A_MASK, 16'h0000);
        wr(A_RISE, 16'h0008);
        port_in[3] = 1'b1;
        waitc(3);
        rd(A_PEND, d); chk("R8 masked still latches", d, 16'h0008);
        chk("R8 masked no request", irqs(), 0);
        wr(A_MASK, 16'h0008);
        chk("R8 R9 unmasked line3 group 2-3", irqs(), 3'b010);

        // R7: edge beats simultaneous clear
        wr(A_FALL, 16'h0008);
        port_in[3] = 1'b0;
        waitc(2);
        wr_en = 1'b1; addr = A_PEND; wr_data = 16'h0008;
        @(negedge clk);
        wr_en = 1'b0;
        rd(A_PEND, d); chk("R7 edge wins over clear", d, 16'h0008);
        wr(A_PEND, 16'h0008);
        rd(A_PEND, d); chk("R6 clear after collision", d, 0);
        chk("R9 request drops after clear", irqs(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule